// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block gives a processor core a small set of performance counters. It has one cycle counter and two event counters. Each event counter is steered by a 5-bit selection code to one of twenty event inputs. Some inputs are per-occurrence strobes. Some are per-cycle stall levels. One is counted once per contiguous stall episode. The write-back input can add two in one cycle. Every counter has a saturating overflow tally beside it.

Software programs the two selection codes and then writes a start command. The start command clears all counts and tallies and begins counting. A stop command freezes every value, and the values stay readable until the next start. All access goes through a single-cycle write port and a combinational read port.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter and every overflow tally reads 0. The control word reads 0 (stopped) and the selection word reads 0.
- R2: While running, the cycle counter (read address 2) gains exactly one on every clock edge.
- R3: Each event counter adds its selected input's contribution on every running clock edge. Counter 0 reads at address 4 and counter 1 at address 6. Codes 0 to 19 select `evt_i[code]`. Code 7 is instruction retired and code 11 is data-cache miss.
- R4: Level codes 1, 2, 8 and 15 count one on every running cycle in which their input is high.
- R5: Code 9 counts one only on a cycle where `evt_i[9]` is high and was low on the previous clock. That previous-cycle sample is taken on every clock, whether or not the unit is running.
- R6: Code 12 adds one when `evt_i[12]` is high and `wb_full_line` is low. It adds two when both are high.
- R7: Code 13 counts only when `evt_i[13]` is high and `pc_mode_change` is low.
- R8: Codes 20 to 31 (0x14 to 0x1F) select no event, and the counter holds its value.
- R9: When a counter wraps past its all-ones value, its overflow tally gains one on that same edge. The tally saturates at its all-ones value. Tallies read at addresses 3, 5 and 7.
- R10: A write to address 0 works as follows. Bit 0 alone means start: it clears all counts and tallies and sets the running bit (read bit 0). Bit 1 means stop, even when bit 0 is also set. On a stop, the running bit clears and all values hold from that edge on.
- R11: Write address 1 holds the selection word: counter 0's code is in bits [4:0] and counter 1's code is in bits [12:8]. A counter uses the code it latched at the last start. Writes to address 1 while running take no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 selection) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| evt_i | input | 20 | Event inputs, one per selection code |
| wb_full_line | input | 1 | The current write-back covers a full line (two halves) |
| pc_mode_change | input | 1 | The current PC write comes with a mode change |

## Verification
The bench builds the unit with 8-bit counters and 3-bit overflow tallies. With these sizes, wrapping takes only 256 cycles and tally saturation takes about two thousand. The saturation path of R9 can therefore be exercised within a short run, and so can a two-step wrap from write-back. The default 32-bit counters only change the widths of the adders and registers. They take the same paths.

// File: rtl/perf_mon_pkg.sv
// Shared constants of the performance monitoring unit: event codes,
// register addresses and command bit positions.
package perf_mon_pkg;
    localparam int N_EVT      = 20;
    localparam int SEL_W      = 5;
    localparam int NUM_EV     = 2;
    localparam int SEL_STRIDE = 8;
    localparam int ADDR_W     = 3;

    // event codes with non-plain counting rules
    localparam logic [SEL_W-1:0] CODE_EPISODE = 5'd9;
    localparam logic [SEL_W-1:0] CODE_WRBACK  = 5'd12;
    localparam logic [SEL_W-1:0] CODE_PCWRITE = 5'd13;
    localparam logic [SEL_W-1:0] CODE_LAST    = SEL_W'(N_EVT - 1);

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEL     = 3'd1;
    localparam logic [ADDR_W-1:0] A_CYC     = 3'd2;
    localparam logic [ADDR_W-1:0] A_CYC_OVF = 3'd3;
    localparam logic [ADDR_W-1:0] A_EV0     = 3'd4;
    localparam logic [ADDR_W-1:0] A_EV0_OVF = 3'd5;
    localparam logic [ADDR_W-1:0] A_EV1     = 3'd6;
    localparam logic [ADDR_W-1:0] A_EV1_OVF = 3'd7;

    localparam int BIT_START = 0;
    localparam int BIT_STOP  = 1;
endpackage

// File: rtl/perf_evt_sel.sv
// Event selector: turns a selection code and the event inputs into a
// per-cycle increment of 0, 1 or 2. Purely combinational. Assumes the
// caller supplies the previous-cycle sample of the episode input.
module perf_evt_sel
    import perf_mon_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    input  logic [N_EVT-1:0] evt,
    input  logic             ep_prev,
    input  logic             wb_full,
    input  logic             mode_chg,
    output logic [1:0]       inc
);
    // decode the increment for the selected event
    always_comb begin
        inc = 2'd0;
        if (code <= CODE_LAST) begin
            if (code == CODE_EPISODE)
                inc = {1'b0, evt[code] & ~ep_prev};
            else if (code == CODE_WRBACK)
                inc = evt[code] ? (wb_full ? 2'd2 : 2'd1) : 2'd0;
            else if (code == CODE_PCWRITE)
                inc = {1'b0, evt[code] & ~mode_chg};
            else
                inc = {1'b0, evt[code]};
        end
    end

    // R8: unused codes never produce an increment
    always_comb begin
        if (code > CODE_LAST)
            unused_code_chk: assert (inc == 2'd0);
    end
endmodule

// File: rtl/perf_counter.sv
// One counter with its overflow tally. Adds inc (0..2) when en is high.
// A carry out of the counter bumps the tally, which saturates. clr takes
// priority over counting. Assumes en is low whenever clr is high.
module perf_counter #(
    parameter int CNT_W = 32,
    parameter int OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] count,
    output logic [OVF_W-1:0] ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    logic [CNT_W:0] sum;
    logic           carry;

    // widened add so the wrap shows up as a carry bit
    always_comb begin
        sum   = {1'b0, count} + (CNT_W + 1)'(inc);
        carry = sum[CNT_W];
    end

    // count register and saturating overflow tally
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            ovf   <= '0;
        end else if (en) begin
            count <= sum[CNT_W-1:0];
            if (carry && ovf != OVF_MAX)
                ovf <= ovf + 1'b1;
        end
    end

    // R9: a wrap from all-ones bumps an unsaturated tally
    wrap_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clr && count == CNT_MAX && inc != 2'd0 && ovf != OVF_MAX
        |=> ovf == $past(ovf) + 1'b1);

    // R9: a saturated tally stays saturated until cleared
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == OVF_MAX && !clr |=> ovf == OVF_MAX);

    // R10: a stopped counter holds all values
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !clr |=> $stable(count) && $stable(ovf));

    // R10: start clears count and tally
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0 && ovf == '0);
endmodule

// File: rtl/perf_mon_unit.sv
// Performance monitoring unit: one cycle counter and two event counters,
// each with an overflow tally, behind a small register port. Start clears
// and runs, stop freezes. Selection codes are latched at start.
// Assumes CNT_W and OVF_W are at most 32.
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OVF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              wb_full_line,
    input  logic              pc_mode_change
);
    logic             running;
    logic             ep_prev;
    logic             ctrl_wr, sel_wr, cmd_start, cmd_stop, cnt_en;
    logic [SEL_W-1:0] sel_q   [NUM_EV];
    logic [SEL_W-1:0] sel_lat [NUM_EV];
    logic [CNT_W-1:0] ev_cnt  [NUM_EV];
    logic [OVF_W-1:0] ev_ovf  [NUM_EV];
    logic [CNT_W-1:0] cyc_cnt;
    logic [OVF_W-1:0] cyc_ovf;

    // command decode; stop wins over start
    always_comb begin
        ctrl_wr   = wr_en && wr_addr == A_CTRL;
        sel_wr    = wr_en && wr_addr == A_SEL;
        cmd_stop  = ctrl_wr && wr_data[BIT_STOP];
        cmd_start = ctrl_wr && wr_data[BIT_START] && !wr_data[BIT_STOP];
        cnt_en    = running && !cmd_stop && !cmd_start;
    end

    // running flag
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (cmd_stop)  running <= 1'b0;
        else if (cmd_start) running <= 1'b1;
    end

    // previous-cycle sample of the episode input, taken every clock
    always_ff @(posedge clk) begin
        if (!rst_n) ep_prev <= 1'b0;
        else        ep_prev <= evt_i[CODE_EPISODE];
    end

    perf_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) cyc_u (
        .clk(clk), .rst_n(rst_n), .clr(cmd_start), .en(cnt_en),
        .inc(2'd1), .count(cyc_cnt), .ovf(cyc_ovf)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        logic [1:0] inc;

        // software-visible selection code
        always_ff @(posedge clk) begin
            if (!rst_n)      sel_q[g] <= '0;
            else if (sel_wr) sel_q[g] <= wr_data[g*SEL_STRIDE +: SEL_W];
        end

        // selection latched at start
        always_ff @(posedge clk) begin
            if (!rst_n)         sel_lat[g] <= '0;
            else if (cmd_start) sel_lat[g] <= sel_q[g];
        end

        perf_evt_sel sel_u (
            .code(sel_lat[g]), .evt(evt_i), .ep_prev(ep_prev),
            .wb_full(wb_full_line), .mode_chg(pc_mode_change), .inc(inc)
        );

        perf_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) cnt_u (
            .clk(clk), .rst_n(rst_n), .clr(cmd_start), .en(cnt_en),
            .inc(inc), .count(ev_cnt[g]), .ovf(ev_ovf[g])
        );

        // R11: the latched code changes only at start
        sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_start |=> $stable(sel_lat[g]));
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:    rd_data[0] = running;
            A_SEL:     for (int i = 0; i < NUM_EV; i++)
                           rd_data[i*SEL_STRIDE +: SEL_W] = sel_q[i];
            A_CYC:     rd_data[CNT_W-1:0] = cyc_cnt;
            A_CYC_OVF: rd_data[OVF_W-1:0] = cyc_ovf;
            A_EV0:     rd_data[CNT_W-1:0] = ev_cnt[0];
            A_EV0_OVF: rd_data[OVF_W-1:0] = ev_ovf[0];
            A_EV1:     rd_data[CNT_W-1:0] = ev_cnt[1];
            default:   rd_data[OVF_W-1:0] = ev_ovf[1];
        endcase
    end

    // R10: a stop command leaves the unit stopped
    stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> !running);

    // R2: while running, the cycle counter steps by one
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> cyc_cnt == $past(cyc_cnt) + 1'b1);
endmodule

// File: tb/perf_mon_unit_tb_top.sv
// Bench: a behavioural reference model updated at each clock edge. The
// bench reads one register per cycle, rotating through the map, and
// compares it with the model.
module perf_mon_unit_tb_top;
    localparam int CW = 8;
    localparam int OW = 3;
    localparam int CMASK = (1 << CW) - 1;
    localparam int OMAX  = (1 << OW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [19:0] evt_i = '0;
    logic        wb_full_line = 1'b0;
    logic        pc_mode_change = 1'b0;

    perf_mon_unit #(.CNT_W(CW), .OVF_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_i(evt_i), .wb_full_line(wb_full_line),
        .pc_mode_change(pc_mode_change)
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_run, m_prev, m_sel[2], m_lat[2], m_cnt[3], m_ovf[3];

    function automatic int ev_inc(int code);
        if (code > 19) return 0;
        if (code == 9)  return (evt_i[9] && !m_prev) ? 1 : 0;
        if (code == 12) return evt_i[12] ? (wb_full_line ? 2 : 1) : 0;
        if (code == 13) return (evt_i[13] && !pc_mode_change) ? 1 : 0;
        return evt_i[code] ? 1 : 0;
    endfunction

    task automatic bump(int k, int inc);
        m_cnt[k] += inc;
        if (m_cnt[k] > CMASK) begin
            m_cnt[k] -= CMASK + 1;
            if (m_ovf[k] < OMAX) m_ovf[k]++;
        end
    endtask

    // model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_prev = 0;
            for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_ovf[k] = 0; end
            for (int k = 0; k < 2; k++) begin m_sel[k] = 0; m_lat[k] = 0; end
        end else begin
            int i0, i1;
            i0 = ev_inc(m_lat[0]);
            i1 = ev_inc(m_lat[1]);
            if (wr_en && wr_addr == 0 && wr_data[1]) begin
                m_run = 0;
            end else if (wr_en && wr_addr == 0 && wr_data[0]) begin
                m_run = 1;
                for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_ovf[k] = 0; end
                m_lat[0] = m_sel[0]; m_lat[1] = m_sel[1];
            end else if (m_run != 0) begin
                bump(0, 1); bump(1, i0); bump(2, i1);
            end
            if (wr_en && wr_addr == 1) begin
                m_sel[0] = int'(wr_data[4:0]);
                m_sel[1] = int'(wr_data[12:8]);
            end
            m_prev = evt_i[9] ? 1 : 0;
        end
    end

    function automatic int expect_rd(logic [2:0] a);
        case (a)
            3'd0: return m_run;
            3'd1: return m_sel[0] | (m_sel[1] << 8);
            3'd2: return m_cnt[0];
            3'd3: return m_ovf[0];
            3'd4: return m_cnt[1];
            3'd5: return m_ovf[1];
            3'd6: return m_cnt[2];
            default: return m_ovf[2];
        endcase
    endfunction

    task automatic check(string req, int got, int exp, string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%0d actual=%0d expected=%0d", req, what,
                     rd_addr, got, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(cur_req, int'(rd_data), expect_rd(rd_addr), "readback");
            rd_addr = rd_addr + 3'd1;
        end
    end

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_rand(int n, logic [19:0] mask);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            evt_i = 20'($urandom) & mask;
            wb_full_line = 1'($urandom);
            pc_mode_change = 1'($urandom);
        end
    endtask

    task automatic run_fixed(int n, logic [19:0] v);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            evt_i = v;
        end
    endtask

    task automatic start_with(int s0, int s1);
        reg_wr(3'd1, 32'(s0) | (32'(s1) << 8));
        reg_wr(3'd0, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        run_fixed(16, '0);

        cur_req = "R2";            // retired instructions and data misses
        start_with(7, 11);
        run_rand(300, '1);

        cur_req = "R3";            // plain strobes on other codes
        start_with(0, 19);
        run_rand(200, '1);

        cur_req = "R4";            // level stalls
        start_with(2, 15);
        run_fixed(20, 20'h08004);
        run_rand(100, '1);

        cur_req = "R5";            // episode against per-cycle level
        start_with(9, 8);
        run_fixed(10, 20'h00300);
        run_fixed(3, '0);
        run_fixed(5, 20'h00300);
        run_rand(200, 20'h00300);

        cur_req = "R6";            // write-back halves
        start_with(12, 12);
        run_rand(300, 20'h01000);

        cur_req = "R7";            // PC writes qualified by mode change
        start_with(13, 7);
        run_rand(200, 20'h02080);

        cur_req = "R8";            // unused codes hold zero
        start_with(20, 31);
        run_fixed(40, '1);

        cur_req = "R9";            // wrap and saturation
        @(negedge clk); wb_full_line = 1'b1;
        start_with(7, 12);
        run_fixed(2200, '1);

        cur_req = "R10";           // stop with both bits, then hold
        reg_wr(3'd0, 32'h3);
        run_rand(60, '1);
        reg_wr(3'd0, 32'h1);
        run_rand(50, '1);
        reg_wr(3'd0, 32'h2);
        run_rand(40, '1);

        cur_req = "R11";           // select writes during a run
        start_with(7, 2);
        run_rand(20, '1);
        reg_wr(3'd1, 32'h0000_0C0D);
        run_rand(100, '1);
        reg_wr(3'd0, 32'h1);
        run_rand(100, '1);

        done = 1;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule